// File: doc/BRIEF.md
# Tunable Oscillator and Quadrature Mixer with Staged Retuning

This block produces a running phase and its cosine and sine for a transmit datapath, and uses them to rotate a stream of complex baseband samples. A phase accumulator advances by a frequency word on every clock. A phase offset is added to the upper half of the accumulator. The top bits of the result index a quarter-wave amplitude table, and the mixer combines that table output with the incoming I and Q samples.

Software reaches the tuning word and the phase offset through a narrow byte-wide write port. Each byte lands in a staging copy only. The running oscillator keeps its current settings until software toggles a commit bit from 0 to 1. At that edge the whole staged tuning word and phase offset replace the active pair together, so the oscillator never runs with half-updated settings.

Top module: `nco_sync_tune`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the staged and active settings, the commit bit, and every output (phase, cosine, sine and both mixer outputs) to zero by the first clock edge after reset.
- R2: A write with `wr_en` high stores `wr_data` in a staging byte. Addresses 0 to 3 hold the tuning word from its least significant byte (address 0) up to its most significant byte (address 3). Address 4 holds the low byte of the phase offset and address 5 holds the high byte. Address 7 has no effect. None of these writes changes the running phase until a commit.
- R3: A write to address 6 loads the commit bit from `wr_data[0]`. When that write takes the bit from 0 to 1, the active tuning word and the active phase offset both take the staged values at the same edge.
- R4: Writing 1 to address 6 while the commit bit is already 1, or leaving it at 1, does not commit again.
- R5: On every clock out of reset the 32-bit accumulator adds the active tuning word, modulo 2^32.
- R6: `phase_o` is the accumulator's upper 16 bits plus the active phase offset, modulo 2^16. It is registered, so it shows the accumulator and offset that held before the previous edge.
- R7: The 10-bit table address is `phase_o[15:6]`. The address's bits [9:8] are the quadrant q and bits [7:0] are the index k. Let A(j) = floor(32767*j*(512-j)/65536) for j from 0 to 256. sine = A(k) in q=0, A(256-k) in q=1, -A(k) in q=2, and -A(256-k) in q=3. cosine is the sine of address+256, modulo 1024. Both appear on `cos_o` and `sin_o` in the same cycle as the `phase_o` they come from.
- R8: Samples on `i_in` and `q_in` are captured alongside the phase. One clock later, `mix_i_o` = (I*cos - Q*sin) >>> 15 and `mix_q_o` = (I*sin + Q*cos) >>> 15. Both are signed 17-bit values that use the captured sample and the `cos_o` and `sin_o` of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0-3 tuning bytes, 4-5 offset bytes, 6 commit bit |
| wr_data | input | 8 | Write data byte |
| i_in | input | 16 | Signed in-phase sample |
| q_in | input | 16 | Signed quadrature sample |
| phase_o | output | 16 | Offset phase word |
| cos_o | output | 16 | Signed cosine of `phase_o` |
| sin_o | output | 16 | Signed sine of `phase_o` |
| mix_i_o | output | 17 | Signed mixer in-phase output |
| mix_q_o | output | 17 | Signed mixer quadrature output |

## Verification
The hardest case to reach from the ports is a commit that must not happen. This needs staged bytes that differ from the active settings while the commit bit is already 1. The stimulus therefore stages a new tuning word during a run, rewrites the commit bit as 1, and watches the phase keep its old step. Only after a 0 is written and then a 1 does the phase change slope. A tuning word of 2^22 steps the table address by exactly one per clock, so a single run visits all 1024 table entries. Extreme sample values are mixed in regularly so that every mixer output range is reached.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ACC_W     = 32;
    localparam int PH_W      = 16;
    localparam int LUT_W     = 10;
    localparam int SMP_W     = 16;
    localparam int ADDR_W    = 3;
    localparam int FTW_BYTES = ACC_W / 8;
    localparam int OFF_BYTES = PH_W / 8;
    localparam int UPD_ADDR  = FTW_BYTES + OFF_BYTES;
    localparam int QN        = 1 << (LUT_W - 2);
    localparam int MIX_W     = SMP_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] ftw;
        logic [PH_W-1:0]  poff;
    } tune_cfg_t;

    // Parabolic quarter-wave magnitude, j in 0..QN
    function automatic logic [SMP_W-1:0] quarter_amp(input int j);
        longint amp;
        longint t;
        amp = (longint'(1) <<< (SMP_W - 1)) - 1;
        t = amp * longint'(j) * longint'(2 * QN - j);
        t = t / (longint'(QN) * longint'(QN));
        return SMP_W'(t);
    endfunction
endpackage

// File: rtl/nco_tune_regs.sv
module nco_tune_regs
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output tune_cfg_t         shd_cfg,
    output tune_cfg_t         act_cfg,
    output logic              upd_bit
);
    logic commit;

    assign commit = wr_en && (wr_addr == ADDR_W'(UPD_ADDR)) && wr_data[0] && !upd_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg <= '0;
            act_cfg <= '0;
            upd_bit <= 1'b0;
        end else begin
            if (wr_en) begin
                for (int b = 0; b < FTW_BYTES; b++) begin
                    if (wr_addr == ADDR_W'(b))
                        shd_cfg.ftw[8*b +: 8] <= wr_data;
                end
                for (int b = 0; b < OFF_BYTES; b++) begin
                    if (wr_addr == ADDR_W'(FTW_BYTES + b))
                        shd_cfg.poff[8*b +: 8] <= wr_data;
                end
                if (wr_addr == ADDR_W'(UPD_ADDR))
                    upd_bit <= wr_data[0];
            end
            if (commit)
                act_cfg <= shd_cfg;
        end
    end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
    import nco_pkg::*;
(
    input  logic [LUT_W-1:0]        addr,
    output logic signed [SMP_W-1:0] cos_v,
    output logic signed [SMP_W-1:0] sin_v
);
    localparam int IDX_W = LUT_W - 2;

    logic [SMP_W-1:0] qtab [0:QN];
    logic signed [SMP_W-1:0] lane_v [2];

    for (genvar g = 0; g <= QN; g++) begin : g_tab
        assign qtab[g] = quarter_amp(g);
    end

    // lane 0 gives sine, lane 1 is a quarter turn ahead and gives cosine
    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [LUT_W-1:0] a;
        logic [IDX_W:0]   fwd;
        logic [IDX_W:0]   rev;
        logic [SMP_W-1:0] mag;
        always_comb begin
            a   = addr + LUT_W'(l * QN);
            fwd = {1'b0, a[IDX_W-1:0]};
            rev = (IDX_W+1)'(QN) - fwd;
            mag = a[LUT_W-2] ? qtab[rev] : qtab[fwd];
            lane_v[l] = a[LUT_W-1] ? -$signed(mag) : $signed(mag);
        end
    end

    assign sin_v = lane_v[0];
    assign cos_v = lane_v[1];
endmodule

// File: rtl/nco_cmix.sv
module nco_cmix
    import nco_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] i_s,
    input  logic signed [SMP_W-1:0] q_s,
    input  logic signed [SMP_W-1:0] cos_s,
    input  logic signed [SMP_W-1:0] sin_s,
    output logic signed [MIX_W-1:0] mix_i,
    output logic signed [MIX_W-1:0] mix_q
);
    localparam int SUM_W = 2 * SMP_W + 1;
    logic signed [SUM_W-1:0] sum_i, sum_q;

    always_comb begin
        sum_i = SUM_W'(i_s * cos_s) - SUM_W'(q_s * sin_s);
        sum_q = SUM_W'(i_s * sin_s) + SUM_W'(q_s * cos_s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_i <= '0;
            mix_q <= '0;
        end else begin
            mix_i <= MIX_W'(sum_i >>> (SMP_W - 1));
            mix_q <= MIX_W'(sum_q >>> (SMP_W - 1));
        end
    end
endmodule

// File: rtl/nco_sync_tune.sv
module nco_sync_tune
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       i_in,
    input  logic [15:0]       q_in,
    output logic [15:0]       phase_o,
    output logic [15:0]       cos_o,
    output logic [15:0]       sin_o,
    output logic [16:0]       mix_i_o,
    output logic [16:0]       mix_q_o
);
    tune_cfg_t shd_cfg, act_cfg;
    logic      upd_bit;

    logic [ACC_W-1:0]        acc_q;
    logic [PH_W-1:0]         ph_c;
    logic signed [SMP_W-1:0] cos_c, sin_c;
    logic signed [SMP_W-1:0] i_r, q_r;

    nco_tune_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .shd_cfg (shd_cfg),
        .act_cfg (act_cfg),
        .upd_bit (upd_bit)
    );

    assign ph_c = acc_q[ACC_W-1 -: PH_W] + act_cfg.poff;

    nco_sincos u_lut (
        .addr  (ph_c[PH_W-1 -: LUT_W]),
        .cos_v (cos_c),
        .sin_v (sin_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            phase_o <= '0;
            cos_o   <= '0;
            sin_o   <= '0;
            i_r     <= '0;
            q_r     <= '0;
        end else begin
            acc_q   <= acc_q + act_cfg.ftw;
            phase_o <= ph_c;
            cos_o   <= cos_c;
            sin_o   <= sin_c;
            i_r     <= i_in;
            q_r     <= q_in;
        end
    end

    nco_cmix u_mix (
        .clk   (clk),
        .rst   (rst),
        .i_s   (i_r),
        .q_s   (q_r),
        .cos_s (cos_o),
        .sin_s (sin_o),
        .mix_i (mix_i_o),
        .mix_q (mix_q_o)
    );
endmodule

// File: rtl/nco_sync_tune_chk.sv
module nco_sync_tune_chk
    import nco_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_bit0,
    input logic [PH_W-1:0]   phase_o,
    input logic [MIX_W-1:0]  mix_i_o,
    input logic [ACC_W-1:0]  acc_q,
    input tune_cfg_t         shd_cfg,
    input tune_cfg_t         act_cfg,
    input logic              upd_bit
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase_o == '0 && mix_i_o == '0 && acc_q == '0 && act_cfg == '0));

    // R2
    hold_active_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADDR_W'(UPD_ADDR) && wr_bit0) |=> $stable(act_cfg));

    // R3
    commit_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(UPD_ADDR) && wr_bit0 && !upd_bit)
        |=> act_cfg == $past(shd_cfg));

    // R4
    no_recommit_chk: assert property (@(posedge clk) disable iff (rst)
        upd_bit |=> $stable(act_cfg));

    // R5
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> acc_q == $past(acc_q + act_cfg.ftw));

    // R6
    phase_out_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase_o == $past(acc_q[ACC_W-1 -: PH_W] + act_cfg.poff));
endmodule

bind nco_sync_tune nco_sync_tune_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit0 (wr_data[0]),
    .phase_o (phase_o),
    .mix_i_o (mix_i_o),
    .acc_q   (acc_q),
    .shd_cfg (shd_cfg),
    .act_cfg (act_cfg),
    .upd_bit (upd_bit)
);

// File: tb/test_nco_sync_tune.sv
`timescale 1ns/1ps
module test_nco_sync_tune;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] i_in = '0;
    logic [15:0] q_in = '0;
    logic [15:0] phase_o, cos_o, sin_o;
    logic [16:0] mix_i_o, mix_q_o;

    int errors = 0;
    int checks = 0;
    int n = 0;
    bit checking = 0;
    bit done = 0;
    string stage = "R1";

    always #2.5 clk = ~clk;

    nco_sync_tune i_nco_sync_tune (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .i_in(i_in), .q_in(q_in), .phase_o(phase_o), .cos_o(cos_o), .sin_o(sin_o),
        .mix_i_o(mix_i_o), .mix_q_o(mix_q_o)
    );

    // reference quantities derived from the requirements
    function automatic longint amp_ref(input int j);
        return (longint'(32767) * j * (512 - j)) / 65536;
    endfunction

    function automatic longint sine_ref(input int a);
        int q, k;
        longint m;
        q = (a >> 8) & 3;
        k = a & 255;
        m = (q & 1) ? amp_ref(256 - k) : amp_ref(k);
        return (q & 2) ? -m : m;
    endfunction

    // cycle model
    longint m_sft, m_aft, m_acc;
    int m_soff, m_aoff, m_ph, m_upd;
    longint m_cos, m_sin, m_i, m_q, m_mi, m_mq;

    always @(posedge clk) begin
        longint nph, ncos, nsin, nmi, nmq;
        if (rst) begin
            m_sft = 0; m_aft = 0; m_acc = 0; m_soff = 0; m_aoff = 0; m_ph = 0; m_upd = 0;
            m_cos = 0; m_sin = 0; m_i = 0; m_q = 0; m_mi = 0; m_mq = 0;
        end else begin
            nph  = ((m_acc >> 16) + m_aoff) & 16'hFFFF;
            nsin = sine_ref(int'(nph >> 6));
            ncos = sine_ref(int'(((nph >> 6) + 256) & 1023));
            nmi  = (m_i * m_cos - m_q * m_sin) >>> 15;
            nmq  = (m_i * m_sin + m_q * m_cos) >>> 15;
            m_acc = (m_acc + m_aft) & 32'hFFFF_FFFF;
            if (wr_en && wr_addr == 6 && wr_data[0] && m_upd == 0) begin
                m_aft = m_sft;
                m_aoff = m_soff;
            end
            if (wr_en) begin
                case (wr_addr)
                    0, 1, 2, 3: m_sft = (m_sft & ~(longint'(255) << (8 * wr_addr)))
                                        | (longint'(wr_data) << (8 * wr_addr));
                    4: m_soff = (m_soff & 16'hFF00) | wr_data;
                    5: m_soff = (m_soff & 16'h00FF) | (int'(wr_data) << 8);
                    6: m_upd = wr_data[0];
                    default: ;
                endcase
            end
            m_ph = int'(nph);
            m_cos = ncos; m_sin = nsin;
            m_i = longint'($signed(i_in)); m_q = longint'($signed(q_in));
            m_mi = nmi; m_mq = nmq;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, n);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            chk(stage, "phase", longint'(phase_o), longint'(m_ph));
            chk(stage == "R1" ? "R1" : "R7", "cos", longint'(cos_o), m_cos & 16'hFFFF);
            chk(stage == "R1" ? "R1" : "R7", "sin", longint'(sin_o), m_sin & 16'hFFFF);
            chk(stage == "R1" ? "R1" : "R8", "mix_i", longint'(mix_i_o), m_mi & 17'h1FFFF);
            chk(stage == "R1" ? "R1" : "R8", "mix_q", longint'(mix_q_o), m_mq & 17'h1FFFF);
        end
    end

    task automatic tick(input bit we = 0, input int a = 0, input int d = 0);
        @(negedge clk);
        n++;
        wr_en = we;
        wr_addr = 3'(a);
        wr_data = 8'(d);
        case (n % 8)
            0: begin i_in = 16'h7FFF; q_in = 16'h8000; end
            1: begin i_in = 16'h8000; q_in = 16'h8000; end
            2: begin i_in = 16'h8000; q_in = 16'h7FFF; end
            3: begin i_in = 16'h7FFF; q_in = 16'h7FFF; end
            default: begin i_in = 16'(n * 7919); q_in = 16'(n * 104729 >> 3); end
        endcase
    endtask

    task automatic run(input int cyc);
        for (int c = 0; c < cyc; c++) tick();
    endtask

    task automatic set_ftw(input logic [31:0] f);
        for (int b = 0; b < 4; b++) tick(1, b, int'(f[8*b +: 8]));
    endtask

    task automatic set_off(input logic [15:0] o);
        tick(1, 4, int'(o[7:0]));
        tick(1, 5, int'(o[15:8]));
    endtask

    task automatic toggle_commit();
        tick(1, 6, 0);
        tick(1, 6, 1);
    endtask

    initial begin
        tick(); tick();
        checking = 1;
        stage = "R1"; run(3);
        rst = 0;
        // R2: staging with zero active settings keeps phase at zero
        stage = "R2"; set_ftw(32'h0040_0000); run(3);
        // R3: commit, then sweep all 1024 table addresses (R7)
        stage = "R3"; tick(1, 6, 1);
        stage = "R5"; run(1100);
        // R2: stage new settings during a run
        stage = "R2"; set_ftw(32'h1234_5679); set_off(16'h4000); tick(1, 7, 8'hFF); run(10);
        // R4: rewrite 1 without clearing, then hold
        stage = "R4"; tick(1, 6, 1); tick(1, 6, 8'h03); run(30);
        stage = "R3"; toggle_commit();
        stage = "R6"; run(200);
        // R5: wraparound with a large step
        stage = "R5"; set_ftw(32'hF000_0001); set_off(16'hFFC0); toggle_commit(); run(400);
        // R1: reset in mid-run
        stage = "R1"; rst = 1; run(3);
        rst = 0; stage = "R5"; run(5);
        checking = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule